// File: doc/BRIEF.md
# Queued Interrupt Entry Controller

This block sits beside the core of a 16-bit processor and owns its hardware interrupt path. Devices post 16-bit messages into an in-order message queue. At each instruction boundary the core raises a decode command. If queue reading is enabled and a message is waiting, the oldest message leaves the queue. When the interrupt vector register holds a nonzero value, the controller enters the handler. It writes the current program counter and then register A below the stack pointer, one word per clock through a single memory port. It then tells the core to load the vector into PC, the message into A and the lowered pointer into SP.

The core also hands four instructions to the block: write the vector, read the vector, turn queue reading on or off, and return from a handler. The controller also runs the software interrupt, which does not use the queue. Each command occupies the block for a fixed number of busy cycles while the core holds PC, A and SP steady. Register changes reach the core as one-cycle load strobes with values. A decode that finds the queue completely full sets a fault flag that stays set until reset.

Top module: `irq_entry_ctrl`

## Requirements
- R1: The queue keeps up to 256 messages (parameter QDEPTH) and releases them in arrival order; `queue_count` gives the number held.
- R2: A message offered on `hw_valid` is dropped, leaving `queue_count` unchanged, when the vector register is zero or the queue already holds 256 messages.
- R3: A decode command accepted while the queue holds 256 messages sets `fault`, which then stays 1 until reset; a full queue alone does not set it.
- R4: A decode with reading disabled or an empty queue removes nothing, writes no memory, raises no load strobe and is busy 1 cycle.
- R5: A decode that removes a message while the vector is nonzero is busy 2 cycles. It writes `cpu_pc` to `cpu_sp-1` in the first cycle and `cpu_a` to `cpu_sp-2` in the second. In that second cycle it also strobes PC=vector, A=message and SP=`cpu_sp-2`, and it leaves reading disabled.
- R6: A decode that removes a message while the vector is zero discards it: no memory write, no load strobe, busy 1 cycle.
- R7: Return (op 5) is busy 3 cycles, reads `cpu_sp` then `cpu_sp+1` (data one cycle after the address), loads A from the first word and PC from the second, strobes SP=`cpu_sp+2` and leaves reading enabled.
- R8: Queue control (op 3) is busy 2 cycles; a nonzero `cmd_arg` disables reading and a zero `cmd_arg` enables it.
- R9: Software interrupt (op 4) is busy 4 cycles and leaves the queue untouched. With a nonzero vector it writes `cmd_ret_pc` to `cpu_sp-1` and `cpu_a` to `cpu_sp-2`, strobes PC=vector and SP=`cpu_sp-2`, and disables reading. With a zero vector it has no effect.
- R10: Write-vector (op 1, value in `cmd_arg`) and read-vector (op 2, value on `cmd_result` with `cmd_done`) are busy 1 cycle each; undefined ops 6 and 7 are 1-cycle no-ops.
- R11: After reset: vector 0, reading enabled, queue empty, `fault` 0, `cmd_ready` 1, `cmd_done` 0, `cmd_result` 0.
- R12: A command is taken on a clock edge with `cmd_valid` and `cmd_ready` (op 0 is decode). `cmd_ready` then stays low for exactly the busy cycles stated above. `cmd_done` pulses for the one cycle after, when `cmd_ready` returns. Memory is never read and written in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hw_valid | input | 1 | Device message offered this cycle |
| hw_msg | input | 16 | Device message value |
| cmd_valid | input | 1 | Command request from the core |
| cmd_op | input | 3 | Command code (0 decode, 1 write vector, 2 read vector, 3 queue control, 4 software interrupt, 5 return) |
| cmd_arg | input | 16 | Command operand |
| cmd_ret_pc | input | 16 | Address following the software interrupt instruction |
| cmd_ready | output | 1 | Block idle, command may be taken |
| cmd_done | output | 1 | One-cycle completion pulse |
| cmd_result | output | 16 | Vector value captured by read-vector |
| cpu_pc | input | 16 | Core program counter |
| cpu_a | input | 16 | Core register A |
| cpu_sp | input | 16 | Core stack pointer |
| pc_load | output | 1 | Strobe: core loads PC |
| pc_value | output | 16 | New PC |
| a_load | output | 1 | Strobe: core loads A |
| a_value | output | 16 | New A |
| sp_load | output | 1 | Strobe: core loads SP |
| sp_value | output | 16 | New SP |
| mem_we | output | 1 | Memory write enable |
| mem_re | output | 1 | Memory read enable (data next cycle) |
| mem_addr | output | 16 | Memory address |
| mem_wdata | output | 16 | Memory write data |
| mem_rdata | input | 16 | Memory read data |
| queue_count | output | 9 | Messages held in the queue |
| reads_enabled | output | 1 | Queue reading enabled |
| fault | output | 1 | Sticky overflow fault |

## Verification
On every cycle, the assertions check four things. The queue never exceeds capacity and a full queue stays full without a removal. The fault flag is set by an overflowing decode and never clears. An entered handler leaves reading disabled and its last push lands where the new stack pointer points. A return's A load is followed by the PC load with the raised pointer, and the single memory port never reads and writes together. Other behaviour is shown only by the bench's directed scenarios. These cover the exact busy length of each command, the pushed words and their order, and the order in which messages leave the queue. They also cover dropping with a zero vector, discarding on decode, the software interrupt with each vector value, and a round trip through the stack.

// File: rtl/irq_pkg.sv
package irq_pkg;

  typedef enum logic [2:0] {
    OP_DECODE   = 3'd0,
    OP_SET_VEC  = 3'd1,
    OP_GET_VEC  = 3'd2,
    OP_QCTL     = 3'd3,
    OP_SOFT_INT = 3'd4,
    OP_RETURN   = 3'd5
  } irq_op_e;

  // busy length of a command; go marks an entry that really pushes
  function automatic logic [2:0] op_len(irq_op_e op, logic go);
    case (op)
      OP_DECODE:   op_len = go ? 3'd2 : 3'd1;
      OP_QCTL:     op_len = 3'd2;
      OP_SOFT_INT: op_len = 3'd4;
      OP_RETURN:   op_len = 3'd3;
      default:     op_len = 3'd1;
    endcase
  endfunction

  // stack grows toward lower addresses
  function automatic logic [15:0] stack_below(logic [15:0] sp, logic [1:0] n);
    stack_below = sp - 16'(n);
  endfunction

  function automatic logic [15:0] stack_above(logic [15:0] sp, logic [1:0] n);
    stack_above = sp + 16'(n);
  endfunction

endpackage

// File: rtl/irq_msg_fifo.sv
module irq_msg_fifo #(
  parameter int W     = 16,
  parameter int DEPTH = 256
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       push,
  input  logic [W-1:0]               push_data,
  input  logic                       pop,
  output logic [W-1:0]               head,
  output logic [$clog2(DEPTH):0]     count
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;

  logic [W-1:0]  store [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt;

  function automatic logic [AW-1:0] step_ptr(logic [AW-1:0] p);
    step_ptr = (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push) store[wp] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push) wp <= step_ptr(wp);
      if (pop)  rp <= step_ptr(rp);
      cnt <= cnt + CW'(push) - CW'(pop);
    end
  end

  assign head  = store[rp];
  assign count = cnt;
endmodule

// File: rtl/irq_step_ctr.sv
module irq_step_ctr #(
  parameter int LW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [LW-1:0] len,
  output logic          busy,
  output logic [LW-1:0] idx,
  output logic          last,
  output logic          done
);
  logic [LW-1:0] len_q;

  assign last = busy && (idx == len_q - 1'b1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      idx   <= '0;
      len_q <= LW'(1);
      done  <= 1'b0;
    end else begin
      done <= last;
      if (start) begin
        busy  <= 1'b1;
        idx   <= '0;
        len_q <= len;
      end else if (busy) begin
        if (last) busy <= 1'b0;
        else      idx  <= idx + 1'b1;
      end
    end
  end
endmodule

// File: rtl/irq_entry_ctrl.sv
module irq_entry_ctrl
  import irq_pkg::*;
#(
  parameter int W      = 16,
  parameter int QDEPTH = 256
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      hw_valid,
  input  logic [W-1:0]              hw_msg,
  input  logic                      cmd_valid,
  input  logic [2:0]                cmd_op,
  input  logic [W-1:0]              cmd_arg,
  input  logic [W-1:0]              cmd_ret_pc,
  output logic                      cmd_ready,
  output logic                      cmd_done,
  output logic [W-1:0]              cmd_result,
  input  logic [W-1:0]              cpu_pc,
  input  logic [W-1:0]              cpu_a,
  input  logic [W-1:0]              cpu_sp,
  output logic                      pc_load,
  output logic [W-1:0]              pc_value,
  output logic                      a_load,
  output logic [W-1:0]              a_value,
  output logic                      sp_load,
  output logic [W-1:0]              sp_value,
  output logic                      mem_we,
  output logic                      mem_re,
  output logic [W-1:0]              mem_addr,
  output logic [W-1:0]              mem_wdata,
  input  logic [W-1:0]              mem_rdata,
  output logic [$clog2(QDEPTH):0]   queue_count,
  output logic                      reads_enabled,
  output logic                      fault
);
  localparam int CW = $clog2(QDEPTH) + 1;

  logic [W-1:0]  vec_q, arg_q, ret_q, msg_q, res_q;
  logic          rden_q, fault_q, go_q;
  irq_op_e       op_q, op_in;
  logic          busy, last, done;
  logic [2:0]    idx, len_in;
  logic [W-1:0]  fifo_head;
  logic [CW-1:0] fifo_cnt;

  // named internal events
  logic accept, dec_hit, dq_ev, take_ev, enq_ev, ovf_ev, go_in;
  logic fifo_full, fifo_empty, vec_set;

  assign op_in      = irq_op_e'(cmd_op);
  assign vec_set    = (vec_q != '0);
  assign fifo_full  = (fifo_cnt == CW'(QDEPTH));
  assign fifo_empty = (fifo_cnt == '0);
  assign accept     = cmd_valid && !busy;
  assign dec_hit    = accept && (op_in == OP_DECODE);
  assign dq_ev      = dec_hit && rden_q && !fifo_empty;
  assign take_ev    = dq_ev && vec_set;
  assign ovf_ev     = dec_hit && (fifo_cnt > CW'(QDEPTH - 1));
  assign enq_ev     = hw_valid && vec_set && !fifo_full;
  assign go_in      = (op_in == OP_SOFT_INT) ? vec_set : take_ev;
  assign len_in     = op_len(op_in, go_in);

  irq_msg_fifo #(.W(W), .DEPTH(QDEPTH)) u_fifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (enq_ev),
    .push_data (hw_msg),
    .pop       (dq_ev),
    .head      (fifo_head),
    .count     (fifo_cnt)
  );

  irq_step_ctr #(.LW(3)) u_step (
    .clk   (clk),
    .rst_n (rst_n),
    .start (accept),
    .len   (len_in),
    .busy  (busy),
    .idx   (idx),
    .last  (last),
    .done  (done)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vec_q   <= '0;
      arg_q   <= '0;
      ret_q   <= '0;
      msg_q   <= '0;
      res_q   <= '0;
      rden_q  <= 1'b1;
      fault_q <= 1'b0;
      go_q    <= 1'b0;
      op_q    <= OP_GET_VEC;
    end else begin
      if (accept) begin
        op_q  <= op_in;
        arg_q <= cmd_arg;
        ret_q <= cmd_ret_pc;
        go_q  <= go_in;
      end
      if (dq_ev)   msg_q   <= fifo_head;
      if (take_ev) rden_q  <= 1'b0;
      if (ovf_ev)  fault_q <= 1'b1;
      if (busy && idx == 3'd0) begin
        case (op_q)
          OP_SET_VEC:  vec_q  <= arg_q;
          OP_GET_VEC:  res_q  <= vec_q;
          OP_QCTL:     rden_q <= (arg_q == '0);
          OP_SOFT_INT: if (go_q) rden_q <= 1'b0;
          OP_RETURN:   rden_q <= 1'b1;
          default:     ;
        endcase
      end
    end
  end

  always_comb begin
    mem_we    = 1'b0;
    mem_re    = 1'b0;
    mem_addr  = '0;
    mem_wdata = '0;
    pc_load   = 1'b0;
    pc_value  = '0;
    a_load    = 1'b0;
    a_value   = '0;
    sp_load   = 1'b0;
    sp_value  = '0;
    if (busy) begin
      case (op_q)
        OP_DECODE, OP_SOFT_INT: begin
          if (go_q) begin
            if (idx == 3'd0) begin
              mem_we    = 1'b1;
              mem_addr  = stack_below(cpu_sp, 2'd1);
              mem_wdata = (op_q == OP_DECODE) ? cpu_pc : ret_q;
            end
            if (idx == 3'd1) begin
              mem_we    = 1'b1;
              mem_addr  = stack_below(cpu_sp, 2'd2);
              mem_wdata = cpu_a;
            end
            if ((op_q == OP_DECODE && idx == 3'd1) ||
                (op_q == OP_SOFT_INT && idx == 3'd2)) begin
              pc_load  = 1'b1;
              pc_value = vec_q;
              sp_load  = 1'b1;
              sp_value = stack_below(cpu_sp, 2'd2);
              if (op_q == OP_DECODE) begin
                a_load  = 1'b1;
                a_value = msg_q;
              end
            end
          end
        end
        OP_RETURN: begin
          if (idx == 3'd0) begin
            mem_re   = 1'b1;
            mem_addr = cpu_sp;
          end
          if (idx == 3'd1) begin
            mem_re   = 1'b1;
            mem_addr = stack_above(cpu_sp, 2'd1);
            a_load   = 1'b1;
            a_value  = mem_rdata;
          end
          if (idx == 3'd2) begin
            pc_load  = 1'b1;
            pc_value = mem_rdata;
            sp_load  = 1'b1;
            sp_value = stack_above(cpu_sp, 2'd2);
          end
        end
        default: ;
      endcase
    end
  end

  assign cmd_ready     = !busy;
  assign cmd_done      = done;
  assign cmd_result    = res_q;
  assign queue_count   = fifo_cnt;
  assign reads_enabled = rden_q;
  assign fault         = fault_q;
endmodule

// File: rtl/irq_entry_chk.sv
module irq_entry_chk #(
  parameter int W      = 16,
  parameter int QDEPTH = 256
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic [$clog2(QDEPTH):0]  queue_count,
  input logic                     fault,
  input logic                     dq_ev,
  input logic                     take_ev,
  input logic                     ovf_ev,
  input logic                     reads_enabled,
  input logic                     mem_we,
  input logic                     mem_re,
  input logic [W-1:0]             mem_addr,
  input logic                     pc_load,
  input logic                     a_load,
  input logic [W-1:0]             sp_value,
  input logic [W-1:0]             cpu_sp,
  input logic                     cmd_ready,
  input logic                     cmd_done
);
  localparam int CW = $clog2(QDEPTH) + 1;

  a_r1_capacity: assert property (@(posedge clk) disable iff (!rst_n)
    queue_count <= CW'(QDEPTH));

  a_r2_full_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (queue_count == CW'(QDEPTH) && !dq_ev) |=> $stable(queue_count));

  a_r3_fault_set: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_ev |=> fault);

  a_r3_fault_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    fault |=> fault);

  a_r5_entry_disables: assert property (@(posedge clk) disable iff (!rst_n)
    take_ev |=> !reads_enabled);

  a_r5_last_push_at_sp: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_load && a_load && mem_we) |-> mem_addr == sp_value);

  a_r7_return_order: assert property (@(posedge clk) disable iff (!rst_n)
    (a_load && mem_re) |=> (pc_load && sp_value == $past(cpu_sp) + 16'd2));

  a_r12_one_port: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_we && mem_re));

  a_r12_done_ready: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_done |-> cmd_ready);
endmodule

bind irq_entry_ctrl irq_entry_chk #(.W(W), .QDEPTH(QDEPTH)) u_chk (.*);

// File: tb/sim_irq_entry_ctrl.sv
`timescale 1ns/1ps
module sim_irq_entry_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        hw_valid = 1'b0;
  logic [15:0] hw_msg = '0;
  logic        cmd_valid = 1'b0;
  logic [2:0]  cmd_op = '0;
  logic [15:0] cmd_arg = '0, cmd_ret_pc = '0;
  logic        cmd_ready, cmd_done;
  logic [15:0] cmd_result;
  logic [15:0] cpu_pc = '0, cpu_a = '0, cpu_sp = '0;
  logic        pc_load, a_load, sp_load, mem_we, mem_re;
  logic [15:0] pc_value, a_value, sp_value, mem_addr, mem_wdata;
  logic [15:0] mem_rdata = '0;
  logic [8:0]  queue_count;
  logic        reads_enabled, fault;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  logic [15:0] bmem [256];

  always #5 clk = ~clk;

  irq_entry_ctrl u0 (.*);

  always @(posedge clk) begin
    if (mem_we) bmem[mem_addr[7:0]] <= mem_wdata;
    if (mem_re) mem_rdata <= bmem[mem_addr[7:0]];
  end

  // per-command observations
  int          busy_n, nw, nr;
  logic [15:0] wa [4], wd [4], ra [4];
  bit          pcl, al, spl;
  logic [15:0] pcv, av, spv;
  bit          done_seen;

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic run_cmd(input logic [2:0] op, input logic [15:0] arg, input logic [15:0] ret);
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_arg = arg; cmd_ret_pc = ret;
    @(negedge clk);
    cmd_valid = 1'b0;
    busy_n = 0; nw = 0; nr = 0; pcl = 0; al = 0; spl = 0;
    while (!cmd_ready) begin
      busy_n++;
      if (mem_we && nw < 4) begin wa[nw] = mem_addr; wd[nw] = mem_wdata; nw++; end
      if (mem_re && nr < 4) begin ra[nr] = mem_addr; nr++; end
      if (pc_load) begin pcl = 1; pcv = pc_value; end
      if (a_load)  begin al = 1;  av = a_value;  end
      if (sp_load) begin spl = 1; spv = sp_value; end
      @(negedge clk);
    end
    done_seen = cmd_done;
  endtask

  task automatic push_msgs(input int n, input logic [15:0] base);
    @(negedge clk);
    for (int i = 0; i < n; i++) begin
      hw_valid = 1'b1; hw_msg = base + 16'(i);
      @(negedge clk);
    end
    hw_valid = 1'b0;
  endtask

  task automatic t_reset;
    chk("R11", "ready", cmd_ready, 1);
    chk("R11", "done", cmd_done, 0);
    chk("R11", "count", queue_count, 0);
    chk("R11", "enabled", reads_enabled, 1);
    chk("R11", "fault", fault, 0);
    chk("R11", "result", cmd_result, 0);
  endtask

  task automatic t_vector;
    run_cmd(3'd1, 16'h0100, 0);
    chk("R10", "set busy", busy_n, 1);
    chk("R12", "done pulse", done_seen, 1);
    run_cmd(3'd2, 0, 0);
    chk("R10", "get busy", busy_n, 1);
    chk("R10", "get value", cmd_result, 16'h0100);
    @(negedge clk);
    chk("R12", "done one cycle", cmd_done, 0);
    run_cmd(3'd7, 0, 0);
    chk("R10", "undefined op busy", busy_n, 1);
  endtask

  task automatic t_enqueue;
    push_msgs(3, 16'hA001);
    chk("R1", "count after 3", queue_count, 3);
  endtask

  task automatic t_entry(input logic [15:0] exp_msg, input int exp_cnt);
    cpu_sp = 16'h0080; cpu_pc = 16'h1234; cpu_a = 16'h5555;
    run_cmd(3'd0, 0, 0);
    chk("R5", "busy", busy_n, 2);
    chk("R5", "writes", nw, 2);
    chk("R5", "push1 addr", wa[0], 16'h007F);
    chk("R5", "push1 data", wd[0], 16'h1234);
    chk("R5", "push2 addr", wa[1], 16'h007E);
    chk("R5", "push2 data", wd[1], 16'h5555);
    chk("R5", "pc", {15'd0, pcl, pcv}, {15'd0, 1'b1, 16'h0100});
    chk("R1", "a = oldest msg", {15'd0, al, av}, {15'd0, 1'b1, exp_msg});
    chk("R5", "sp", {15'd0, spl, spv}, {15'd0, 1'b1, 16'h007E});
    chk("R5", "enabled cleared", reads_enabled, 0);
    chk("R1", "count", queue_count, 9'(exp_cnt));
  endtask

  task automatic t_blocked;
    run_cmd(3'd0, 0, 0);
    chk("R4", "busy", busy_n, 1);
    chk("R4", "no writes", nw, 0);
    chk("R4", "no loads", {pcl, al, spl}, 0);
    chk("R4", "count kept", queue_count, 2);
  endtask

  task automatic t_return;
    cpu_sp = 16'h007E;
    run_cmd(3'd5, 0, 0);
    chk("R7", "busy", busy_n, 3);
    chk("R7", "reads", nr, 2);
    chk("R7", "read1 addr", ra[0], 16'h007E);
    chk("R7", "read2 addr", ra[1], 16'h007F);
    chk("R7", "a", {15'd0, al, av}, {15'd0, 1'b1, 16'h5555});
    chk("R7", "pc", {15'd0, pcl, pcv}, {15'd0, 1'b1, 16'h1234});
    chk("R7", "sp", {15'd0, spl, spv}, {15'd0, 1'b1, 16'h0080});
    chk("R7", "enabled", reads_enabled, 1);
    chk("R12", "no writes", nw, 0);
  endtask

  task automatic t_qctl;
    run_cmd(3'd3, 0, 0);
    chk("R8", "busy", busy_n, 2);
    chk("R8", "zero enables", reads_enabled, 1);
    run_cmd(3'd3, 16'h0005, 0);
    chk("R8", "nonzero disables", reads_enabled, 0);
    run_cmd(3'd3, 0, 0);
    chk("R8", "re-enabled", reads_enabled, 1);
  endtask

  task automatic t_softint;
    cpu_sp = 16'h0080; cpu_a = 16'h7777;
    run_cmd(3'd4, 0, 16'h2000);
    chk("R9", "busy", busy_n, 4);
    chk("R9", "writes", nw, 2);
    chk("R9", "push1", {wa[0], wd[0]}, {16'h007F, 16'h2000});
    chk("R9", "push2", {wa[1], wd[1]}, {16'h007E, 16'h7777});
    chk("R9", "pc", {15'd0, pcl, pcv}, {15'd0, 1'b1, 16'h0100});
    chk("R9", "sp", {15'd0, spl, spv}, {15'd0, 1'b1, 16'h007E});
    chk("R9", "a untouched", al, 0);
    chk("R9", "queue untouched", queue_count, 1);
    chk("R9", "enabled cleared", reads_enabled, 0);
    run_cmd(3'd3, 0, 0);
  endtask

  task automatic t_zero_vector;
    run_cmd(3'd1, 16'h0000, 0);
    push_msgs(1, 16'hB000);
    chk("R2", "dropped with zero vector", queue_count, 1);
    run_cmd(3'd0, 0, 0);
    chk("R6", "busy", busy_n, 1);
    chk("R6", "no writes", nw, 0);
    chk("R6", "no loads", {pcl, al, spl}, 0);
    chk("R6", "discarded", queue_count, 0);
    chk("R6", "enabled kept", reads_enabled, 1);
    run_cmd(3'd4, 0, 16'h3000);
    chk("R9", "zero vector busy", busy_n, 4);
    chk("R9", "zero vector no effect", {nw[2:0], pcl, spl}, 0);
    chk("R9", "zero vector enabled", reads_enabled, 1);
  endtask

  task automatic t_overflow;
    run_cmd(3'd1, 16'h0300, 0);
    push_msgs(257, 16'hC000);
    chk("R2", "full drop", queue_count, 256);
    chk("R3", "full alone no fault", fault, 0);
    cpu_sp = 16'h0080;
    run_cmd(3'd0, 0, 0);
    chk("R3", "fault set", fault, 1);
    chk("R1", "first msg out", av, 16'hC000);
    chk("R1", "count after pop", queue_count, 255);
    run_cmd(3'd3, 0, 0);
    chk("R3", "fault sticky", fault, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_vector;
    t_enqueue;
    t_entry(16'hA001, 2);
    t_blocked;
    t_return;
    t_entry(16'hA002, 1);
    t_qctl;
    t_softint;
    t_zero_vector;
    t_overflow;
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule